// File: doc/BRIEF.md
# Address-Keyed Execute-in-Place Stream Cipher

This block encrypts and decrypts execute-in-place memory traffic on the fly. It never runs the data through the block cipher. It runs the access address through AES-128 under a secret key instead. The 128-bit input block is a 96-bit initialization vector joined to the 16-byte-aligned access address. The resulting ciphertext is used as a pad and XORed with the data beat. The same XOR serves both read data coming from external memory and write data heading to it. The pad is never visible to software.

Software writes the key words, the IV words and an enable flag through a small register port. Key words always read back as zero. An access is presented as an address and a 32-bit data beat with a valid/ready handshake. The core expands the round keys on the fly and runs one round per clock. A result beat therefore leaves a fixed number of cycles after its request is taken. When the enable flag is clear, beats pass through unchanged with the same timing.

Top module: `xip_addr_cipher`

## Requirements
- R1: The pad source is the AES-128 forward cipher of the plaintext {IV[95:0], addr[31:4], 4'b0000} under KEY[127:0]. Byte 0 of every AES block and of the key is bits [127:120].
- R2: The register port writes on cfg_we. Offset k in 0..3 holds KEY[32k+31:32k]. Offset 4+k in 0..2 holds IV[32k+31:32k]. Offset 7 bit 0 is the enable flag. IV words and the enable flag read back on cfg_rdata, which is combinational from cfg_addr.
- R3: Reads at offsets 0..3 (key) always return zero. Reads at offsets 8..15 also return zero.
- R4: With the enable flag set at acceptance, data_out = data_in XOR CT[32j+31:32j], where CT is the R1 ciphertext and j = addr[3:2].
- R5: Address bits [3:0] do not change the ciphertext. Accesses within one 16-byte block use words of one common pad, and bits [1:0] are ignored entirely.
- R6: With the enable flag clear at acceptance, data_out equals data_in.
- R7: data_out_valid is a one-cycle pulse in the cycle after the 11th rising edge following the acceptance edge. data_out stays stable until the next result.
- R8: A request is accepted only when req_valid and req_ready are both high. req_ready is low from acceptance until the result cycle and high in the result cycle. Requests presented while req_ready is low produce no result.
- R9: Key, IV and enable values are captured at acceptance. Writes made while a request is in flight do not alter that request's result, and they apply to the next request.
- R10: After reset, req_ready is 1, data_out_valid is 0, and the key, IV and enable registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (key words read as zero) |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Unit can take a request |
| req_addr | input | 32 | Access byte address |
| data_in | input | 32 | Data beat to transform, taken with the request |
| data_out_valid | output | 1 | Result beat valid pulse |
| data_out | output | 32 | Transformed data beat |

## Verification
Two pairs of events can fall in the same cycle. First, a result beat leaves in the very cycle the next request is accepted. The bench provokes this by queuing requests back to back, so the driver raises req_valid as soon as req_ready returns. Second, a key, IV or enable write can land while a request is mid-round. Forked register writes provoke this a few cycles after acceptance. A scoreboard judges both cases. Its expected value uses the register values captured at acceptance, and every beat is matched by data and by arrival cycle. The next request must then show the newly written values.

// File: rtl/xip_addr_cipher.sv
module xip_addr_cipher (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic [31:0] data_in,
  output logic        data_out_valid,
  output logic [31:0] data_out
);

  localparam int          ROUNDS   = 10;
  localparam logic [3:0]  LAST_RND = 4'(ROUNDS);
  localparam logic [3:0]  OUT_STEP = 4'(ROUNDS + 1);

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] sb(input logic [7:0] x);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 7; i >= 0; i--) begin
      r = gmul(r, r);
      if (i != 0) r = gmul(r, x);
    end
    return r ^ rotl8(r, 1) ^ rotl8(r, 2) ^ rotl8(r, 3) ^ rotl8(r, 4) ^ 8'h63;
  endfunction

  function automatic logic [127:0] key_step(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] w0, w1, w2, w3, t;
    w0 = k[127:96];
    w1 = k[95:64];
    w2 = k[63:32];
    w3 = k[31:0];
    t  = {sb(w3[23:16]) ^ rc, sb(w3[15:8]), sb(w3[7:0]), sb(w3[31:24])};
    w0 = w0 ^ t;
    w1 = w1 ^ w0;
    w2 = w2 ^ w1;
    w3 = w3 ^ w2;
    return {w0, w1, w2, w3};
  endfunction

  function automatic logic [127:0] enc_round(input logic [127:0] s, input logic [127:0] k,
                                             input logic last);
    logic [7:0]   b [16];
    logic [7:0]   h [16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) b[i] = sb(s[127-8*i -: 8]);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        h[r+4*c] = b[r+4*((c+r)%4)];
    for (int c = 0; c < 4; c++) begin
      logic [7:0] a0, a1, a2, a3;
      a0 = h[4*c];
      a1 = h[4*c+1];
      a2 = h[4*c+2];
      a3 = h[4*c+3];
      if (last) begin
        o[127-32*c -: 32] = {a0, a1, a2, a3};
      end else begin
        o[127-32*c -: 32] = {xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
                             a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
                             a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
                             xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
      end
    end
    return o ^ k;
  endfunction

  logic [127:0] key_q;
  logic [95:0]  iv_q;
  logic         en_q;
  logic [3:0]   cnt_q;
  logic [127:0] st_q, rk_q;
  logic [7:0]   rc_q;
  logic [31:0]  din_q;
  logic [1:0]   sel_q;
  logic         pass_q;

  logic         accept;
  logic [127:0] rk_next, st_next;
  logic [31:0]  pad;
  logic         unused_wbits;

  assign accept       = req_valid & req_ready;
  assign req_ready    = (cnt_q == 4'd0);
  assign rk_next      = key_step(rk_q, rc_q);
  assign st_next      = enc_round(st_q, rk_next, cnt_q == LAST_RND);
  assign pad          = st_q[32*sel_q +: 32];
  assign unused_wbits = ^cfg_wdata[31:1];

  always_comb begin
    case (cfg_addr)
      4'd4:    cfg_rdata = iv_q[31:0];
      4'd5:    cfg_rdata = iv_q[63:32];
      4'd6:    cfg_rdata = iv_q[95:64];
      4'd7:    cfg_rdata = {31'd0, en_q};
      default: cfg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      iv_q  <= '0;
      en_q  <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        4'd0: key_q[31:0]   <= cfg_wdata;
        4'd1: key_q[63:32]  <= cfg_wdata;
        4'd2: key_q[95:64]  <= cfg_wdata;
        4'd3: key_q[127:96] <= cfg_wdata;
        4'd4: iv_q[31:0]    <= cfg_wdata;
        4'd5: iv_q[63:32]   <= cfg_wdata;
        4'd6: iv_q[95:64]   <= cfg_wdata;
        4'd7: en_q          <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q          <= 4'd0;
      st_q           <= '0;
      rk_q           <= '0;
      rc_q           <= 8'h01;
      din_q          <= '0;
      sel_q          <= 2'd0;
      pass_q         <= 1'b0;
      data_out_valid <= 1'b0;
      data_out       <= '0;
    end else begin
      data_out_valid <= 1'b0;
      if (accept) begin
        cnt_q  <= 4'd1;
        st_q   <= {iv_q, req_addr[31:4], 4'b0000} ^ key_q;
        rk_q   <= key_q;
        rc_q   <= 8'h01;
        din_q  <= data_in;
        sel_q  <= req_addr[3:2];
        pass_q <= ~en_q;
      end else if (cnt_q == OUT_STEP) begin
        cnt_q          <= 4'd0;
        data_out_valid <= 1'b1;
        data_out       <= pass_q ? din_q : (din_q ^ pad);
      end else if (cnt_q != 4'd0) begin
        cnt_q <= cnt_q + 4'd1;
        st_q  <= st_next;
        rk_q  <= rk_next;
        rc_q  <= xt(rc_q);
      end
    end
  end

endmodule

// File: rtl/xip_addr_cipher_chk.sv
module xip_addr_cipher_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  cfg_addr,
  input logic [31:0] cfg_rdata,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] data_in,
  input logic        data_out_valid,
  input logic [31:0] data_out,
  input logic        en_q
);

  logic        acc;
  logic [3:0]  ck_cnt;
  logic [31:0] ck_din;
  logic        ck_pass;

  assign acc = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_cnt  <= 4'd0;
      ck_din  <= '0;
      ck_pass <= 1'b0;
    end else if (acc) begin
      ck_cnt  <= 4'd1;
      ck_din  <= data_in;
      ck_pass <= ~en_q;
    end else if (ck_cnt != 4'd0 && ck_cnt != 4'd15) begin
      ck_cnt <= ck_cnt + 4'd1;
    end
  end

  assert_key_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr < 4'd4) |-> (cfg_rdata == 32'd0));

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);

  assert_ready_with_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_out_valid |-> req_ready);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_out_valid |=> !data_out_valid);

  // counter holds 1 after the acceptance edge, so 12 is seen 11 edges later
  assert_fixed_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_out_valid |-> (ck_cnt == 4'd12));

  assert_bypass_unchanged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_out_valid && ck_pass) |-> (data_out == ck_din));

endmodule

bind xip_addr_cipher xip_addr_cipher_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .req_valid(req_valid), .req_ready(req_ready), .data_in(data_in),
  .data_out_valid(data_out_valid), .data_out(data_out), .en_q(en_q)
);

// File: tb/tb_xip_addr_cipher.sv
`timescale 1ns/1ps
module tb_xip_addr_cipher;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = 4'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [31:0] data_in = '0;
  logic        data_out_valid;
  logic [31:0] data_out;

  xip_addr_cipher dut (.*);

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int n_sent = 0;
  int n_seen = 0;
  bit done = 1'b0;

  logic [127:0] sh_key = '0;
  logic [95:0]  sh_iv = '0;
  logic         sh_en = 1'b0;

  logic [31:0] q_data[$];
  int          q_cyc[$];
  string       q_tag[$];

  logic [7:0] exp_t [256];
  logic [7:0] log_t [256];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] mx2(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] msbox(input logic [7:0] x);
    logic [7:0] inv, o, c;
    inv = (x == 8'h00) ? 8'h00 : exp_t[(255 - int'(log_t[x])) % 255];
    c = 8'h63;
    for (int i = 0; i < 8; i++)
      o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
    return o;
  endfunction

  function automatic logic [127:0] model_aes(input logic [127:0] key, input logic [127:0] pt);
    logic [7:0] k[16], s[16], t[16];
    logic [7:0] rc, k12, k13, k14, k15;
    logic [127:0] res;
    rc = 8'h01;
    for (int i = 0; i < 16; i++) begin
      k[i] = key[127-8*i -: 8];
      s[i] = pt[127-8*i -: 8] ^ k[i];
    end
    for (int r = 1; r <= 10; r++) begin
      k12 = k[12]; k13 = k[13]; k14 = k[14]; k15 = k[15];
      k[0] = k[0] ^ msbox(k13) ^ rc;
      k[1] = k[1] ^ msbox(k14);
      k[2] = k[2] ^ msbox(k15);
      k[3] = k[3] ^ msbox(k12);
      for (int i = 4; i < 16; i++) k[i] = k[i] ^ k[i-4];
      rc = mx2(rc);
      for (int i = 0; i < 16; i++) t[i] = msbox(s[(i%4) + 4*(((i/4) + (i%4)) % 4)]);
      for (int c = 0; c < 4; c++) begin
        for (int rr = 0; rr < 4; rr++) begin
          if (r == 10)
            s[4*c+rr] = t[4*c+rr];
          else
            s[4*c+rr] = mx2(t[4*c+rr]) ^ mx2(t[4*c+(rr+1)%4]) ^ t[4*c+(rr+1)%4]
                        ^ t[4*c+(rr+2)%4] ^ t[4*c+(rr+3)%4];
        end
      end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ k[i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  function automatic logic [31:0] expect_beat(input logic [31:0] a, input logic [31:0] d);
    logic [127:0] ct;
    if (!sh_en) return d;
    ct = model_aes(sh_key, {sh_iv, a[31:4], 4'b0000});
    return d ^ ct[32*a[3:2] +: 32];
  endfunction

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    case (a)
      4'd0: sh_key[31:0]   = d;
      4'd1: sh_key[63:32]  = d;
      4'd2: sh_key[95:64]  = d;
      4'd3: sh_key[127:96] = d;
      4'd4: sh_iv[31:0]    = d;
      4'd5: sh_iv[63:32]   = d;
      4'd6: sh_iv[95:64]   = d;
      4'd7: sh_en          = d[0];
      default: ;
    endcase
  endtask

  task automatic cfg_read_check(input logic [3:0] a, input logic [31:0] expv, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(cfg_rdata == expv, tag, cfg_rdata, expv);
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; data_in = d;
    @(posedge clk); #1;
    q_data.push_back(expect_beat(a, d));
    q_cyc.push_back(cyc + 11);
    q_tag.push_back(tag);
    n_sent++;
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && data_out_valid) begin
      n_seen++;
      if (q_data.size() == 0) begin
        check(1'b0, "R8 unexpected result", data_out, 0);
      end else begin
        logic [31:0] ed;
        int ec;
        string tg;
        ed = q_data.pop_front();
        ec = q_cyc.pop_front();
        tg = q_tag.pop_front();
        check(data_out == ed, tg, data_out, ed);
        check(cyc == ec, "R7 latency", cyc, ec);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    logic [7:0] e;
    e = 8'h01;
    for (int i = 0; i < 255; i++) begin
      exp_t[i] = e;
      log_t[e] = 8'(i);
      e = e ^ mx2(e);
    end
    exp_t[255] = 8'h01;
    log_t[0] = 8'h00;

    check(model_aes(128'h2b7e151628aed2a6abf7158809cf4f3c,
                    128'h3243f6a8885a308d313198a2e0370734)
          == 128'h3925841d02dc09fbdc118597196a0b32, "R1 bench model self-test",
          model_aes(128'h2b7e151628aed2a6abf7158809cf4f3c,
                    128'h3243f6a8885a308d313198a2e0370734),
          128'h3925841d02dc09fbdc118597196a0b32);

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
    check(data_out_valid == 1'b0, "R10 valid after reset", data_out_valid, 0);
    cfg_read_check(4'd4, 32'd0, "R10 iv word0 reset");
    cfg_read_check(4'd6, 32'd0, "R10 iv word2 reset");
    cfg_read_check(4'd7, 32'd0, "R10 enable reset");

    cfg_write(4'd0, 32'h09cf4f3c);
    cfg_write(4'd1, 32'habf71588);
    cfg_write(4'd2, 32'h28aed2a6);
    cfg_write(4'd3, 32'h2b7e1516);
    cfg_write(4'd4, 32'h13579bdf);
    cfg_write(4'd5, 32'h2468ace0);
    cfg_write(4'd6, 32'hfedcba98);
    cfg_write(4'd7, 32'h00000001);
    cfg_write(4'd9, 32'hffffffff);

    cfg_read_check(4'd0, 32'd0, "R3 key word0 reads zero");
    cfg_read_check(4'd3, 32'd0, "R3 key word3 reads zero");
    cfg_read_check(4'd9, 32'd0, "R3 unused offset reads zero");
    cfg_read_check(4'd4, 32'h13579bdf, "R2 iv word0 readback");
    cfg_read_check(4'd5, 32'h2468ace0, "R2 iv word1 readback");
    cfg_read_check(4'd6, 32'hfedcba98, "R2 iv word2 readback");
    cfg_read_check(4'd7, 32'h00000001, "R2 enable readback");

    send(32'h1000_0000, 32'h0000_0000, "R1 pad word0 zero data");
    send(32'h1000_0004, 32'hffff_ffff, "R4 pad word1");
    send(32'h1000_0008, 32'ha5a5_5a5a, "R4 pad word2");
    send(32'h1000_000c, 32'h1234_5678, "R4 pad word3");
    send(32'h1000_000d, 32'h1234_5678, "R5 low bits ignored");
    send(32'h1000_000f, 32'h1234_5678, "R5 low bits ignored again");
    send(32'hdead_bee0, 32'hcafe_f00d, "R1 other block");
    send(32'hffff_fff8, 32'h0f0f_0f0f, "R1 top address");

    send(32'h2000_0010, 32'h1111_1111, "R8 accepted before junk");
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h7777_7770; data_in = 32'h5555_5555;
    check(req_ready == 1'b0, "R8 ready low while busy", req_ready, 0);
    repeat (5) @(negedge clk);
    req_valid = 1'b0;

    cfg_write(4'd7, 32'h0000_0000);
    send(32'h3000_0000, 32'hbeef_0001, "R6 bypass");
    send(32'h3000_0004, 32'h0000_0000, "R6 bypass zero");
    cfg_write(4'd7, 32'h0000_0001);

    fork
      send(32'h4000_0020, 32'h0bad_c0de, "R9 key write in flight");
      begin
        repeat (4) @(negedge clk);
        cfg_write(4'd2, 32'h0102_0304);
        cfg_write(4'd5, 32'hf0e1_d2c3);
        cfg_write(4'd7, 32'h0000_0000);
      end
    join
    send(32'h4000_0020, 32'h0bad_c0de, "R9 new values apply next");
    cfg_write(4'd7, 32'h0000_0001);
    send(32'h4000_0024, 32'h0bad_c0de, "R9 new key encrypted");

    send(32'h5000_0000, 32'h0101_0101, "R4 back-to-back a");
    send(32'h5000_0014, 32'h0202_0202, "R4 back-to-back b");
    send(32'h5000_0028, 32'h0303_0303, "R4 back-to-back c");

    while (q_data.size() != 0) @(negedge clk);
    repeat (15) @(negedge clk);
    check(n_seen == n_sent, "R8 result count", n_seen, n_sent);
    finish_run();
  end

endmodule